// File: doc/BRIEF.md
# Register File with Built-In Program Counter

This block is a sixteen-entry, 32-bit register file for a statically scheduled datapath. Four read ports return register contents combinationally and two write ports update registers at the clock edge. The top register (index 15) also holds the program counter. There is no separate PC register: the top entry is a general-purpose register that anything can read or overwrite.

Every cycle, a hidden step port writes a new PC value into register 15. That value comes from a dedicated adder. When the taken flag is low, it is the current PC plus 8, which is one 64-bit instruction word. When the flag is high, it is the current PC plus a signed jump distance. The step port has the lowest priority. An explicit write to register 15 through either normal port replaces the step value, which is how an absolute jump is made.

Each register picks one write source per cycle through a small selector. Its states are HOLD (keep the value), PORT (take the data of the winning write port) and STEP (take the adder result, used only by register 15 when no port targets it). A port write to a register moves it from HOLD or STEP to PORT for that edge. With no matching port, an ordinary register goes to HOLD and register 15 goes to STEP.

Top module: `regfile_pc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all sixteen registers, including the PC, to zero.
- R2: Each of the four read ports independently returns, in the same cycle, the current contents of the register at its address.
- R3: A write port with its enable high stores its data into its addressed register at the clock edge. With the enable low it changes nothing.
- R4: When both write ports target the same register in one cycle, port 0 wins and port 1's data is discarded. This includes register 15.
- R5: There is no write-through. A read of a register being written in the same cycle returns the old value.
- R6: With the taken flag low and no port writing register 15, the PC (register 15) increases by 8 at each edge, wrapping modulo 2^32.
- R7: With the taken flag high and no port writing register 15, the PC becomes the old PC plus jump_delta, where jump_delta is a 32-bit two's-complement value and the sum wraps modulo 2^32.
- R8: A port write to register 15 overrides the PC step at that edge, whatever the taken flag is.
- R9: pc_out always equals register 15, and a read port addressing 15 returns the same value.
- R10: When the taken flag is low, jump_delta has no effect on the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr | input | 4x4 | Read addresses, one 4-bit field per port |
| rd_data | output | 4x32 | Read data, one 32-bit field per port |
| wr_en | input | 2 | Write enables, bit p for port p |
| wr_addr | input | 2x4 | Write addresses, one per port |
| wr_data | input | 2x32 | Write data, one per port |
| jump_taken | input | 1 | Condition flag: high selects PC + jump_delta |
| jump_delta | input | 32 | Signed jump distance in bytes |
| pc_out | output | 32 | Current program counter (register 15) |

## Verification
The assertions check the PC every cycle: the clearing after reset, the step by 8, the branch sum, the override by a port write including port 0 priority at register 15, and that read ports addressing 15 agree with pc_out. Port priority, write enables and the absence of write-through on the other fifteen registers cannot be seen from the PC. The bench's reference model shows those by comparing all four read buses every cycle under directed patterns and random traffic. The bench also covers the clearing of every register by reset and the fact that jump_delta is ignored when the flag is low.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Write source chosen for a register at the next clock edge.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_PORT = 2'd1,
        SRC_STEP = 2'd2
    } wsrc_e;
endpackage

// File: rtl/rf_wr_sel.sv
// Per-register write-source selector. Lowest-numbered enabled port that
// targets this register wins; otherwise HOLD, or STEP for the PC entry.
module rf_wr_sel
    import rf_pkg::*;
#(
    parameter int NWR   = 2,
    parameter int AW    = 4,
    parameter int IDX   = 0,
    parameter bit IS_PC = 1'b0,
    localparam int PW   = (NWR > 1) ? $clog2(NWR) : 1
) (
    input  logic [NWR-1:0]         wr_en,
    input  logic [NWR-1:0][AW-1:0] wr_addr,
    output wsrc_e                  src,
    output logic [PW-1:0]          port
);
    always_comb begin
        src  = IS_PC ? SRC_STEP : SRC_HOLD;
        port = '0;
        for (int p = NWR - 1; p >= 0; p--) begin
            if (wr_en[p] && (wr_addr[p] == AW'(IDX))) begin
                src  = SRC_PORT;
                port = PW'(p);
            end
        end
    end
endmodule

// File: rtl/rf_pc_step.sv
// Dedicated PC adder: sequential step or taken jump.
module rf_pc_step #(
    parameter int DW   = 32,
    parameter int STEP = 8
) (
    input  logic [DW-1:0] pc,
    input  logic          taken,
    input  logic [DW-1:0] delta,
    output logic [DW-1:0] pc_next
);
    logic [DW-1:0] incr;
    always_comb begin
        incr    = taken ? delta : DW'(STEP);
        pc_next = pc + incr;
    end
endmodule

// File: rtl/rf_rd_port.sv
// One asynchronous read port.
module rf_rd_port #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int AW   = 4
) (
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [AW-1:0]           addr,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = regs[addr];
    end
endmodule

// File: rtl/regfile_pc.sv
module regfile_pc
    import rf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int NRD  = 4,
    parameter int NWR  = 2,
    parameter int STEP = 8,
    localparam int AW     = $clog2(NREG),
    localparam int PC_IDX = NREG - 1,
    localparam int PW     = (NWR > 1) ? $clog2(NWR) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0][DW-1:0] rd_data,
    input  logic [NWR-1:0]         wr_en,
    input  logic [NWR-1:0][AW-1:0] wr_addr,
    input  logic [NWR-1:0][DW-1:0] wr_data,
    input  logic                   jump_taken,
    input  logic [DW-1:0]          jump_delta,
    output logic [DW-1:0]          pc_out
);
    logic [DW-1:0]           regs_q [NREG];
    logic [NREG-1:0][DW-1:0] regs_flat;
    logic [DW-1:0]           pc_next;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_flat[i] = regs_q[i];
        end
    end

    assign pc_out = regs_q[PC_IDX];

    rf_pc_step #(.DW(DW), .STEP(STEP)) u_step (
        .pc      (regs_q[PC_IDX]),
        .taken   (jump_taken),
        .delta   (jump_delta),
        .pc_next (pc_next)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        wsrc_e         src;
        logic [PW-1:0] port;

        rf_wr_sel #(
            .NWR   (NWR),
            .AW    (AW),
            .IDX   (g),
            .IS_PC (g == PC_IDX)
        ) u_sel (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .src     (src),
            .port    (port)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else begin
                unique case (src)
                    SRC_HOLD: regs_q[g] <= regs_q[g];
                    SRC_PORT: regs_q[g] <= wr_data[port];
                    SRC_STEP: regs_q[g] <= pc_next;
                    default:  regs_q[g] <= regs_q[g];
                endcase
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        rf_rd_port #(.NREG(NREG), .DW(DW), .AW(AW)) u_rd (
            .regs (regs_flat),
            .addr (rd_addr[r]),
            .data (rd_data[r])
        );
    end
endmodule

// File: rtl/rf_pc_chk.sv
module rf_pc_chk #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int NRD  = 4,
    parameter int NWR  = 2,
    parameter int STEP = 8,
    localparam int AW  = $clog2(NREG),
    localparam int PC  = NREG - 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NRD-1:0][AW-1:0] rd_addr,
    input logic [NRD-1:0][DW-1:0] rd_data,
    input logic [NWR-1:0]         wr_en,
    input logic [NWR-1:0][AW-1:0] wr_addr,
    input logic [NWR-1:0][DW-1:0] wr_data,
    input logic                   jump_taken,
    input logic [DW-1:0]          jump_delta,
    input logic [DW-1:0]          pc_out
);
    logic hit0, hit1, hit_any;
    always_comb begin
        hit0    = wr_en[0] && (wr_addr[0] == AW'(PC));
        hit1    = wr_en[1] && (wr_addr[1] == AW'(PC));
        hit_any = 1'b0;
        for (int p = 0; p < NWR; p++) begin
            if (wr_en[p] && (wr_addr[p] == AW'(PC))) hit_any = 1'b1;
        end
    end

    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> (pc_out == '0));

    a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!hit_any && !jump_taken) |=> (pc_out == $past(pc_out) + DW'(STEP)));

    a_r7_branch_sum: assert property (@(posedge clk) disable iff (rst)
        (!hit_any && jump_taken) |=> (pc_out == $past(pc_out) + $past(jump_delta)));

    a_r8_port0_override: assert property (@(posedge clk) disable iff (rst)
        hit0 |=> (pc_out == $past(wr_data[0])));

    a_r4_port1_yields: assert property (@(posedge clk) disable iff (rst)
        (hit1 && !hit0) |=> (pc_out == $past(wr_data[1])));

    for (genvar r = 0; r < NRD; r++) begin : g_r9
        a_r9_pc_visible: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[r] == AW'(PC)) |-> (rd_data[r] == pc_out));
    end
endmodule

bind regfile_pc rf_pc_chk #(
    .NREG (NREG),
    .DW   (DW),
    .NRD  (NRD),
    .NWR  (NWR),
    .STEP (STEP)
) u_rf_pc_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .jump_taken (jump_taken),
    .jump_delta (jump_delta),
    .pc_out     (pc_out)
);

// File: tb/tb_regfile_pc.sv
`timescale 1ns/1ps
module tb_regfile_pc;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int NRD  = 4;
    localparam int NWR  = 2;
    localparam int AW   = 4;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NRD-1:0][AW-1:0] rd_addr;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic [NWR-1:0]         wr_en;
    logic [NWR-1:0][AW-1:0] wr_addr;
    logic [NWR-1:0][DW-1:0] wr_data;
    logic                   jump_taken;
    logic [DW-1:0]          jump_delta;
    logic [DW-1:0]          pc_out;

    regfile_pc dut (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .jump_taken(jump_taken), .jump_delta(jump_delta), .pc_out(pc_out)
    );

    always #5 clk = ~clk;

    int          total = 0;
    int          bad   = 0;
    logic [31:0] mdl [NREG];
    bit          armed = 0;
    bit          wr_last [NREG];
    bit          both_last [NREG];
    string       pc_tag = "R1";
    string       rd_tag = "";

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst = 0; wr_en = '0; wr_addr = '0; wr_data = '0;
        jump_taken = 0; jump_delta = '0; rd_addr = '0;
    endtask

    // One clock: inputs already driven after a falling edge.
    task automatic cycle();
        logic [31:0] nxt [NREG];
        bit          wnow [NREG];
        #1;
        for (int i = 0; i < NREG; i++) wnow[i] = 0;
        for (int p = 0; p < NWR; p++) if (wr_en[p]) wnow[wr_addr[p]] = 1;
        if (armed) begin
            chk(pc_tag, pc_out, mdl[15]);
            for (int r = 0; r < NRD; r++) begin
                string t;
                int a = int'(rd_addr[r]);
                if (rd_tag != "")       t = rd_tag;
                else if (a == 15)       t = "R9";
                else if (wnow[a])       t = "R5";
                else if (both_last[a])  t = "R4";
                else if (wr_last[a])    t = "R3";
                else                    t = "R2";
                chk(t, rd_data[r], mdl[a]);
            end
        end
        for (int i = 0; i < NREG; i++) begin
            nxt[i] = mdl[i];
            wr_last[i] = wnow[i];
            both_last[i] = 0;
        end
        nxt[15] = mdl[15] + (jump_taken ? jump_delta : 32'd8);
        if (wr_en[1]) nxt[wr_addr[1]] = wr_data[1];
        if (wr_en[0]) nxt[wr_addr[0]] = wr_data[0];
        if (wr_en[0] && wr_en[1] && wr_addr[0] == wr_addr[1]) both_last[wr_addr[0]] = 1;
        if (rst)                                    pc_tag = "R1";
        else if (both_last[15])                     pc_tag = "R4";
        else if (wnow[15])                          pc_tag = "R8";
        else if (jump_taken)                        pc_tag = "R7";
        else if (jump_delta != 0)                   pc_tag = "R10";
        else                                        pc_tag = "R6";
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                nxt[i] = '0; wr_last[i] = 0; both_last[i] = 0;
            end
        end
        @(posedge clk);
        for (int i = 0; i < NREG; i++) mdl[i] = nxt[i];
        if (rst) armed = 1;
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mdl[i] = '0; wr_last[i] = 0; both_last[i] = 0;
        end
        idle_inputs();
        rst = 1;
        @(negedge clk);
        // R1: reset clears everything, garbage writes ignored during reset
        wr_en = 2'b11; wr_addr[0] = 4'd3; wr_data[0] = 32'hDEAD_BEEF;
        wr_addr[1] = 4'd15; wr_data[1] = 32'h1234_5678;
        cycle();
        rst_cycle_checks();

        // R3, R5: write two registers, read one of them in the same cycle
        idle_inputs();
        wr_en = 2'b11; wr_addr[0] = 4'd3; wr_data[0] = 32'hA5A5_0003;
        wr_addr[1] = 4'd5; wr_data[1] = 32'h5A5A_0005;
        rd_addr[0] = 4'd3; rd_addr[1] = 4'd5; rd_addr[2] = 4'd15; rd_addr[3] = 4'd0;
        cycle();
        idle_inputs();
        rd_addr[0] = 4'd3; rd_addr[1] = 4'd5; rd_addr[2] = 4'd15;
        cycle();

        // R4: both ports to one register, port 0 wins
        idle_inputs();
        wr_en = 2'b11; wr_addr[0] = 4'd7; wr_data[0] = 32'h0000_C0DE;
        wr_addr[1] = 4'd7; wr_data[1] = 32'hFFFF_0BAD;
        cycle();
        idle_inputs();
        rd_addr[0] = 4'd7;
        cycle();

        // R3: disabled write leaves register 3 unchanged
        idle_inputs();
        wr_en = 2'b00; wr_addr[0] = 4'd3; wr_data[0] = 32'h0BAD_0BAD;
        cycle();
        idle_inputs();
        rd_addr[0] = 4'd3;
        rd_tag = "R3";
        cycle();
        rd_tag = "";

        // R7: taken jumps, forward and backward
        idle_inputs();
        jump_taken = 1; jump_delta = 32'h0000_0100;
        cycle();
        jump_delta = -32'sd24;
        cycle();
        // R10: delta ignored with flag low
        idle_inputs();
        jump_delta = 32'h0005_5550;
        cycle();
        cycle();
        // R8: absolute jump through port 1 while a branch is taken
        idle_inputs();
        jump_taken = 1; jump_delta = 32'h40;
        wr_en = 2'b10; wr_addr[1] = 4'd15; wr_data[1] = 32'h0000_8000;
        cycle();
        idle_inputs();
        wr_en = 2'b01; wr_addr[0] = 4'd15; wr_data[0] = 32'hFFFF_FFF8;
        cycle();
        // R6: wrap past zero
        idle_inputs();
        rd_addr[1] = 4'd15;
        cycle();
        // R4 on the PC
        idle_inputs();
        wr_en = 2'b11; wr_addr[0] = 4'd15; wr_data[0] = 32'h0000_1000;
        wr_addr[1] = 4'd15; wr_data[1] = 32'h0000_2000;
        cycle();
        idle_inputs();
        cycle();

        // Random traffic with one reset in the middle
        for (int n = 0; n < 400; n++) begin
            idle_inputs();
            rst = (n == 200);
            for (int p = 0; p < NWR; p++) begin
                wr_en[p]   = ($urandom_range(0, 2) != 0);
                wr_addr[p] = AW'($urandom_range(0, NREG - 1));
                wr_data[p] = $urandom;
            end
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'($urandom_range(0, NREG - 1));
            jump_taken = ($urandom_range(0, 3) == 0);
            jump_delta = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom;
            cycle();
            if (n == 200) rst_cycle_checks();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // After a reset edge: read every register back as zero (R1).
    task automatic rst_cycle_checks();
        for (int k = 0; k < NREG / NRD; k++) begin
            idle_inputs();
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'(k * NRD + r);
            rd_tag = "R1";
            cycle();
        end
        rd_tag = "";
    endtask
endmodule